// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit register file and a 32-bit data memory port. On a load it takes the word returned by memory and uses the access size and the low address bits to select a byte, halfword or word. It then sign-extends that value to the full register width. On a store it places the register data on the correct byte lanes of the memory word and raises only the byte enables those lanes need. Both paths are combinational and settle in the same cycle as the request.

Every request is checked against the alignment rule for its size. A request that breaks the rule raises a one-cycle address-error output and never reaches memory.

Byte order is taken from an input pin. A small state machine samples that pin on every clock edge while reset is held. The state machine has three states:

- `ORD_RESET`: no sample has been taken yet.
- `ORD_BIG`: big-endian order.
- `ORD_LITTLE`: little-endian order.

While reset is held, the only transitions are into `ORD_BIG` when the pin is high and into `ORD_LITTLE` when it is low. Once reset is released, the state holds itself until the next reset, whatever the pin does.

Top module: `ldst_align`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the byte order from `endian_pin` (1 = big, 0 = little). After reset is released, `big_endian_mode` stays constant regardless of `endian_pin`.
- R2: A byte load (`req_size` = 0) at offset k = `req_addr[1:0]` returns the sign-extended byte from `mem_rdata` bits 8k+7:8k in little-endian order, or bits 31-8k:24-8k in big-endian order.
- R3: A halfword load (`req_size` = 1) at offset 0 returns the sign-extended `mem_rdata[15:0]` in little-endian order or `mem_rdata[31:16]` in big-endian order. At offset 2 the two halves swap.
- R4: A word load (`req_size` = 2) at offset 0 returns `mem_rdata` unchanged in either order.
- R5: A byte store drives `req_wdata[7:0]` on all four lanes of `mem_wdata`. It raises exactly one `mem_be` bit: lane k in little-endian order, lane 3-k in big-endian order. `mem_be` bit j covers data bits 8j+7:8j.
- R6: A halfword store drives `req_wdata[15:0]` on both halves of `mem_wdata`. At offset 0 it raises `mem_be` = 0011 (little) or 1100 (big); at offset 2 the two values swap.
- R7: A word store drives `req_wdata` unchanged with `mem_be` = 1111.
- R8: `addr_err` goes high, in the cycle of the request only, for a halfword at an odd address, for a word whose address bits 1:0 are nonzero, and for size code 3. A byte access never raises it.
- R9: While `addr_err` is high, `mem_req`, `mem_we` and `mem_be` are all zero and `load_result` is zero.
- R10: With `req_valid` low, `mem_req`, `mem_we`, `mem_be`, `addr_err` and `load_result` are all zero.
- R11: `mem_addr` equals `req_addr` with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; byte order is sampled while it is low |
| endian_pin | input | 1 | Byte order select: 1 = big, 0 = little |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = reserved |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Register data for stores, right-aligned |
| mem_rdata | input | 32 | Word returned by memory |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit j for bits 8j+7:8j |
| mem_wdata | output | 32 | Lane-steered store data |
| load_result | output | 32 | Sign-extended load value |
| addr_err | output | 1 | Alignment error for the current request |
| big_endian_mode | output | 1 | Captured byte order |

## Verification
Alignment checking and lane steering act on the same request in the same cycle. A misaligned store therefore both computes lane enables and raises an error, and the error has to win. The bench drives misaligned halfword and word stores and loads, with data that would light lanes, in both byte orders. It judges the cycle by checking that `addr_err` is high while `mem_req`, `mem_be` and `load_result` are zero, and that the error is gone on the next idle cycle. The byte-order lock is provoked by toggling the pin after reset and confirming that the lane choice does not move.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    typedef enum logic [1:0] {
        ORD_RESET  = 2'd0,
        ORD_BIG    = 2'd1,
        ORD_LITTLE = 2'd2
    } order_state_t;

endpackage

// File: rtl/ldst_order_latch.sv
module ldst_order_latch
    import ldst_align_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic endian_pin,
    output logic big_endian
);

    order_state_t state_q;
    order_state_t state_d;

    // Next state: sample the pin only while reset is held.
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = endian_pin ? ORD_BIG : ORD_LITTLE;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ORD_BIG:    big_endian = 1'b1;
            ORD_LITTLE: big_endian = 1'b0;
            ORD_RESET:  big_endian = 1'b0;
            default:    big_endian = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldst_align_check.sv
module ldst_align_check
    import ldst_align_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  acc_size_t        size,
    input  logic [OFS_W-1:0] ofs,
    output logic             misaligned
);

    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ofs[0];
            SZ_WORD: misaligned = |ofs;
            SZ_RSVD: misaligned = 1'b1;
            default: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              big_endian,
    input  acc_size_t         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);

    logic [7:0] byte_at [NB];

    // Memory byte at each address offset, by byte order.
    for (genvar k = 0; k < NB; k++) begin : g_ofs
        always_comb begin
            byte_at[k] = big_endian ? rdata[8*(NB-1-k) +: 8] : rdata[8*k +: 8];
        end
    end

    logic [OFS_W-1:0] ofs_nx;
    logic [7:0]       sel_b;
    logic [15:0]      sel_h;
    logic [DATA_W-1:0] sel_w;

    always_comb begin
        ofs_nx = ofs + OFS_W'(1);
        sel_b  = byte_at[ofs];
        sel_h  = big_endian ? {byte_at[ofs], byte_at[ofs_nx]}
                            : {byte_at[ofs_nx], byte_at[ofs]};
        for (int i = 0; i < NB; i++) begin
            if (big_endian) sel_w[8*(NB-1-i) +: 8] = byte_at[i];
            else            sel_w[8*i +: 8]        = byte_at[i];
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){sel_b[7]}}, sel_b};
            SZ_HALF: value = {{(DATA_W-16){sel_h[15]}}, sel_h};
            SZ_WORD: value = sel_w;
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
    import ldst_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              big_endian,
    input  acc_size_t         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lane_data,
    output logic [NB-1:0]     lane_en
);

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [OFS_W-1:0] lane_ofs;
        logic             hi_part;

        always_comb begin
            lane_ofs = big_endian ? OFS_W'(NB-1-j) : OFS_W'(j);
            hi_part  = big_endian ? ~lane_ofs[0] : lane_ofs[0];
        end

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_data[8*j +: 8] = wdata[7:0];
                    lane_en[j]          = (lane_ofs == ofs);
                end
                SZ_HALF: begin
                    lane_data[8*j +: 8] = hi_part ? wdata[15:8] : wdata[7:0];
                    lane_en[j]          = (lane_ofs[OFS_W-1:1] == ofs[OFS_W-1:1]);
                end
                SZ_WORD: begin
                    lane_data[8*j +: 8] = wdata[8*j +: 8];
                    lane_en[j]          = 1'b1;
                end
                default: begin
                    lane_data[8*j +: 8] = 8'h00;
                    lane_en[j]          = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ldst_align.sv
module ldst_align
    import ldst_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              endian_pin,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NB-1:0]     mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] load_result,
    output logic              addr_err,
    output logic              big_endian_mode
);

    acc_size_t         size;
    logic [OFS_W-1:0]  ofs;
    logic              misaligned;
    logic [DATA_W-1:0] ld_value;
    logic [NB-1:0]     st_en;
    logic              go;

    assign size = acc_size_t'(req_size);
    assign ofs  = req_addr[OFS_W-1:0];

    ldst_order_latch u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .endian_pin (endian_pin),
        .big_endian (big_endian_mode)
    );

    ldst_align_check #(.OFS_W(OFS_W)) u_check (
        .size       (size),
        .ofs        (ofs),
        .misaligned (misaligned)
    );

    ldst_load_extract #(.DATA_W(DATA_W)) u_load (
        .big_endian (big_endian_mode),
        .size       (size),
        .ofs        (ofs),
        .rdata      (mem_rdata),
        .value      (ld_value)
    );

    ldst_store_steer #(.DATA_W(DATA_W)) u_store (
        .big_endian (big_endian_mode),
        .size       (size),
        .ofs        (ofs),
        .wdata      (req_wdata),
        .lane_data  (mem_wdata),
        .lane_en    (st_en)
    );

    always_comb begin
        go          = req_valid && !misaligned;
        addr_err    = req_valid && misaligned;
        mem_req     = go;
        mem_we      = go && req_write;
        mem_be      = go ? st_en : '0;
        mem_addr    = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        load_result = (go && !req_write) ? ld_value : '0;
    end

endmodule

// File: rtl/ldst_align_checker.sv
module ldst_align_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_size,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NB-1:0]     mem_be,
    input logic [DATA_W-1:0] load_result,
    input logic              addr_err,
    input logic              big_endian_mode
);

    assert_order_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(big_endian_mode));

    assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'd0) |-> $countones(mem_be) == 1);

    assert_half_two_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'd1) |-> $countones(mem_be) == 2);

    assert_word_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'd2) |-> &mem_be);

    assert_byte_never_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |-> !addr_err);

    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!mem_req && !mem_we && mem_be == '0 && load_result == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_req && !addr_err && mem_be == '0));

    assert_word_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFS_W-1:0] == '0);

endmodule

bind ldst_align ldst_align_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_size        (req_size),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_be          (mem_be),
    .load_result     (load_result),
    .addr_err        (addr_err),
    .big_endian_mode (big_endian_mode)
);

// File: tb/sim_ldst_align.sv
`timescale 1ns/1ps
module sim_ldst_align;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        endian_pin;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] mem_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] load_result;
    logic        addr_err;
    logic        big_endian_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ldst_align u0 (
        .clk(clk), .rst_n(rst_n), .endian_pin(endian_pin),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .load_result(load_result),
        .addr_err(addr_err), .big_endian_mode(big_endian_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx8(input logic [31:0] v);
        return {{24{v[7]}}, v[7:0]};
    endfunction

    function automatic logic [31:0] sx16(input logic [31:0] v);
        return {{16{v[15]}}, v[15:0]};
    endfunction

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = 32'h0; req_wdata = 32'h0;
        #1;
    endtask

    task automatic drive(input logic wr, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        #1;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; endian_pin = pin;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
    endtask

    // R1, R10: reset capture and quiet idle outputs
    task automatic t_reset(input logic pin);
        do_reset(pin);
        chk("R1 captured order", {31'd0, big_endian_mode}, {31'd0, pin});
        chk("R10 idle mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10 idle mem_be", {28'd0, mem_be}, 32'd0);
        chk("R10 idle addr_err", {31'd0, addr_err}, 32'd0);
        chk("R10 idle load_result", load_result, 32'd0);
    endtask

    // R2, R3, R4, R11: loads in the current byte order
    task automatic t_loads(input logic big);
        mem_rdata = 32'h807FC315;
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 2'd0, 32'h1000 + k, 32'h0);
            chk("R2 byte load", load_result,
                sx8(mem_rdata >> (big ? (24 - 8*k) : (8*k))));
            chk("R11 word address", mem_addr, 32'h1000);
            chk("R2 byte load req", {31'd0, mem_req}, 32'd1);
        end
        mem_rdata = 32'h12348765;
        for (int k = 0; k < 4; k += 2) begin
            drive(1'b0, 2'd1, 32'h2002 + k - 2, 32'h0);
            chk("R3 half load", load_result,
                sx16(mem_rdata >> (big ? (16 - 8*k) : (8*k))));
        end
        drive(1'b0, 2'd2, 32'h3004, 32'h0);
        chk("R4 word load", load_result, 32'h12348765);
        chk("R4 load no write strobe", {31'd0, mem_we}, 32'd0);
        idle();
    endtask

    // R5, R6, R7: stores in the current byte order
    task automatic t_stores(input logic big);
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 2'd0, 32'h4000 + k, 32'hA1B2C3D4);
            chk("R5 byte store data", mem_wdata, 32'hD4D4D4D4);
            chk("R5 byte store be", {28'd0, mem_be},
                32'd1 << (big ? (3 - k) : k));
            chk("R5 byte store we", {31'd0, mem_we}, 32'd1);
        end
        for (int k = 0; k < 4; k += 2) begin
            drive(1'b1, 2'd1, 32'h5000 + k, 32'hA1B2C3D4);
            chk("R6 half store data", mem_wdata, 32'hC3D4C3D4);
            chk("R6 half store be", {28'd0, mem_be},
                (big ? (k == 0) : (k == 2)) ? 32'hC : 32'h3);
        end
        drive(1'b1, 2'd2, 32'h6008, 32'hA1B2C3D4);
        chk("R7 word store data", mem_wdata, 32'hA1B2C3D4);
        chk("R7 word store be", {28'd0, mem_be}, 32'hF);
        idle();
    endtask

    // R8, R9: misaligned requests collide with lane steering
    task automatic t_errors();
        mem_rdata = 32'hFFFFFFFF;
        for (int a = 1; a < 4; a += 2) begin
            drive(1'b1, 2'd1, 32'h7000 + a, 32'hFFFF);
            chk("R8 odd half error", {31'd0, addr_err}, 32'd1);
            chk("R9 error blocks req", {31'd0, mem_req}, 32'd0);
            chk("R9 error blocks be", {28'd0, mem_be}, 32'd0);
            chk("R9 error blocks we", {31'd0, mem_we}, 32'd0);
        end
        for (int a = 1; a < 4; a++) begin
            drive(1'b0, 2'd2, 32'h7100 + a, 32'h0);
            chk("R8 word misalign error", {31'd0, addr_err}, 32'd1);
            chk("R9 error zero load", load_result, 32'd0);
            chk("R9 error blocks req", {31'd0, mem_req}, 32'd0);
        end
        drive(1'b1, 2'd3, 32'h7200, 32'h0);
        chk("R8 reserved size error", {31'd0, addr_err}, 32'd1);
        chk("R9 reserved blocks be", {28'd0, mem_be}, 32'd0);
        idle();
        chk("R8 error is a single pulse", {31'd0, addr_err}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            drive(1'b0, 2'd0, 32'h7300 + a, 32'h0);
            chk("R8 byte never errors", {31'd0, addr_err}, 32'd0);
        end
        idle();
    endtask

    // R1: pin changes after reset are ignored
    task automatic t_lock(input logic pin);
        @(negedge clk);
        endian_pin = ~pin;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 order held", {31'd0, big_endian_mode}, {31'd0, pin});
        drive(1'b1, 2'd0, 32'h8000, 32'h55);
        chk("R1 lane unchanged", {28'd0, mem_be}, pin ? 32'h8 : 32'h1);
        idle();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; endian_pin = 1'b0; mem_rdata = 32'h0;
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = 32'h0; req_wdata = 32'h0;
        for (int p = 0; p < 2; p++) begin
            t_reset(p[0]);
            t_loads(p[0]);
            t_stores(p[0]);
            t_errors();
            t_lock(p[0]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule